// File: doc/BRIEF.md
# Symbol Snapshot Buffer

The block records one block of consecutive I/Q mixer output symbols. Next to each symbol it keeps the sine and cosine values that produced that symbol. An external processor arms a capture with a single control write. The block then fills its buffer from the next valid samples and stops. Afterwards the processor reads the stored words back for symbol-error, phase-rotation and equalizer work.

The processor port is a small strobe bus:

- a 9-bit word address covering 512 words;
- a 16-bit data path, split at the block edge into an input, an output and an output-enable for the pad driver;
- active-low chip-select, read and write strobes.

The strobes are sampled on the block clock.

Control and status words sit at the bottom of the address space. The capture buffer occupies the upper half.

The capture sequencer has four states:

- **CAP_IDLE** leaves reset and waits. A valid arm write moves it to CAP_ARMED.
- **CAP_ARMED** waits for a valid sample. That sample is stored as entry 0, and the sequencer moves to CAP_FILL, or straight to CAP_DONE when the depth is one.
- **CAP_FILL** stores every valid sample. It moves to CAP_DONE when the last entry is written.
- **CAP_DONE** holds the buffer frozen until a new arm write moves it back to CAP_ARMED.

The bus strobe decoder has two states:

- **BUS_IDLE** takes a write on the clock where the write strobe is first seen, and moves to BUS_WR_HOLD.
- **BUS_WR_HOLD** waits for the strobes to drop, then returns to BUS_IDLE.

Top module: `snap_capture_top`

## Requirements
- R1: After reset the status word reads 0 (bits 0 and 1 both clear), and with no strobes active the data output enable is low and the data output is 0.
- R2: Read data is driven, with the output enable high, only while chip-select and read are both low. If either strobe is high, the enable is low and the data output is 0. The read data reflects the address that was presented at the previous clock edge.
- R3: A write to address 0 with data bit 0 set arms a capture. The status word at address 1 then shows bit 1 (armed) set and bit 0 (done) clear. Done and armed are never set together.
- R4: An armed capture stores exactly 64 samples. Each one is taken on a clock where the sample-valid input is high, and clocks with valid low are skipped. After the 64th sample, status reads done = 1 and armed = 0.
- R5: Sample n (0..63) is stored at word address 256 + 4n. The four words are, in order: I at offset 0, Q at offset 1, sine at offset 2 and cosine at offset 3.
- R6: Once done, further valid samples leave the buffer unchanged. A new arm write clears done, sets armed, and the next 64 valid samples overwrite the buffer.
- R7: Processor writes to addresses 256 to 511 are ignored, and the stored words keep their values.
- R8: A write to address 0 with bit 0 clear does not arm. An arm write while samples are being collected is ignored, and the capture still ends after 64 samples in total. A write strobe held low over several clocks counts as one write.
- R9: Address 0 and the unmapped addresses 2 to 255 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample-valid qualifier for the four sample inputs |
| smp_i | input | 16 | In-phase mixer output |
| smp_q | input | 16 | Quadrature mixer output |
| smp_sin | input | 16 | Sine value used for this sample |
| smp_cos | input | 16 | Cosine value used for this sample |
| bus_addr | input | 9 | Processor word address |
| bus_din | input | 16 | Processor write data |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_dout | output | 16 | Read data, 0 when not driven |
| bus_dout_en | output | 1 | Pad output enable for read data |

## Verification
The bench feeds samples with gaps in the valid stream. A sequencer that counted clocks instead of valid samples would therefore store the wrong words or finish early. It re-arms in the middle of a fill and holds the write strobe for several clocks. A design that restarted on that write, or took a held strobe twice, would shift every later entry. After done it keeps driving samples and writes into the capture region. Both check that the frozen block survives, which a sequencer that wrapped around or a decoder that accepted those writes would corrupt. It also asserts chip-select and read separately, to catch a read path that drives the bus on one strobe alone.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_ARMED,
        CAP_FILL,
        CAP_DONE
    } cap_state_t;

    typedef enum logic {
        BUS_IDLE,
        BUS_WR_HOLD
    } bus_state_t;

    typedef enum logic [1:0] {
        SEL_ZERO,
        SEL_STAT,
        SEL_BUF
    } rd_sel_t;

endpackage

// File: rtl/snap_bus_if.sv
module snap_bus_if
    import snap_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              rd_active,
    output logic              arm_req
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    bus_state_t state_q, state_d;
    logic       wr_act;
    logic       ctl_unused;

    assign wr_act     = !cs_n && !wr_n;
    assign ctl_unused = ^din[DATA_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:    if (wr_act)  state_d = BUS_WR_HOLD;
            BUS_WR_HOLD: if (!wr_act) state_d = BUS_IDLE;
            default:     state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_active = !cs_n && !rd_n;
        arm_req   = (state_q == BUS_IDLE) && wr_act && (addr == CTRL_A) && din[0];
    end

endmodule

// File: rtl/snap_capture_fsm.sv
module snap_capture_fsm
    import snap_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_req,
    input  logic             smp_valid,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             st_done,
    output logic             st_armed
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    cap_state_t       state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             last_hit;

    assign last_hit = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (state_d == CAP_ARMED)  cnt_q <= '0;
        else if (wr_en)                 cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:  if (arm_req) state_d = CAP_ARMED;
            CAP_ARMED: if (smp_valid) state_d = last_hit ? CAP_DONE : CAP_FILL;
            CAP_FILL:  if (smp_valid && last_hit) state_d = CAP_DONE;
            CAP_DONE:  if (arm_req) state_d = CAP_ARMED;
            default:   state_d = CAP_IDLE;
        endcase
    end

    always_comb begin
        wr_en    = 1'b0;
        st_done  = 1'b0;
        st_armed = 1'b0;
        unique case (state_q)
            CAP_IDLE:  ;
            CAP_ARMED: begin wr_en = smp_valid; st_armed = 1'b1; end
            CAP_FILL:  begin wr_en = smp_valid; st_armed = 1'b1; end
            CAP_DONE:  st_done = 1'b1;
            default:   ;
        endcase
        wr_idx = cnt_q;
    end

endmodule

// File: rtl/snap_buffer.sv
module snap_buffer #(
    parameter  int DEPTH  = 64,
    parameter  int LANES  = 4,
    parameter  int DATA_W = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LANES*DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [LANE_W-1:0]       rd_lane,
    output logic [DATA_W-1:0]       rd_word
);

    logic [DATA_W-1:0] lane_rd [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_data[l*DATA_W +: DATA_W];
        end

        assign lane_rd[l] = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        rd_word <= lane_rd[rd_lane];
    end

endmodule

// File: rtl/snap_capture_top.sv
module snap_capture_top
    import snap_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int LANES     = 4,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 9,
    parameter int CAP_BASE  = 256,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] smp_q,
    input  logic [DATA_W-1:0] smp_sin,
    input  logic [DATA_W-1:0] smp_cos,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en
);

    localparam int IDX_W     = $clog2(DEPTH);
    localparam int LANE_W    = $clog2(LANES);
    localparam int CAP_WORDS = DEPTH * LANES;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CAP_BASE);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic                    rd_active;
    logic                    arm_req;
    logic                    wr_en;
    logic [IDX_W-1:0]        wr_idx;
    logic                    st_done;
    logic                    st_armed;
    logic [LANES*DATA_W-1:0] lane_data;
    logic [ADDR_W-1:0]       cap_off;
    logic                    in_cap;
    logic [IDX_W-1:0]        rd_idx;
    logic [LANE_W-1:0]       rd_lane;
    logic [DATA_W-1:0]       buf_word;
    logic [DATA_W-1:0]       stat_word;
    logic [DATA_W-1:0]       stat_q;
    logic [DATA_W-1:0]       dout_raw;
    rd_sel_t                 sel_d, sel_q;
    logic                    off_unused;

    snap_bus_if #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (bus_cs_n),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .addr     (bus_addr),
        .din      (bus_din),
        .rd_active(rd_active),
        .arm_req  (arm_req)
    );

    snap_capture_fsm #(
        .DEPTH(DEPTH)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_req  (arm_req),
        .smp_valid(smp_valid),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .st_done  (st_done),
        .st_armed (st_armed)
    );

    assign lane_data = {smp_cos, smp_sin, smp_q, smp_i};

    assign cap_off    = bus_addr - BASE_A;
    assign in_cap     = (bus_addr >= BASE_A) && (32'(cap_off) < CAP_WORDS);
    assign rd_lane    = cap_off[LANE_W-1:0];
    assign rd_idx     = cap_off[LANE_W +: IDX_W];
    assign off_unused = ^cap_off;

    snap_buffer #(
        .DEPTH (DEPTH),
        .LANES (LANES),
        .DATA_W(DATA_W)
    ) u_buf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(lane_data),
        .rd_idx (rd_idx),
        .rd_lane(rd_lane),
        .rd_word(buf_word)
    );

    always_comb begin
        stat_word    = '0;
        stat_word[0] = st_done;
        stat_word[1] = st_armed;
        if (in_cap)                 sel_d = SEL_BUF;
        else if (bus_addr == STAT_A) sel_d = SEL_STAT;
        else                        sel_d = SEL_ZERO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_ZERO;
            stat_q <= '0;
        end else begin
            sel_q  <= sel_d;
            stat_q <= stat_word;
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_BUF:  dout_raw = buf_word;
            SEL_STAT: dout_raw = stat_q;
            default:  dout_raw = '0;
        endcase
        bus_dout_en = rd_active;
        bus_dout    = rd_active ? dout_raw : '0;
    end

endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk #(
    parameter  int DEPTH  = 64,
    parameter  int DATA_W = 16,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_req,
    input logic              smp_valid,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              st_done,
    input logic              st_armed,
    input logic              bus_dout_en,
    input logic [DATA_W-1:0] bus_dout
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // R4: an entry is written only on a valid sample
    assert_write_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> smp_valid);

    // R4: entries fill in consecutive order
    assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != LAST) |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)));

    // R4: the last entry ends the capture
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == LAST) |=> (st_done && !st_armed));

    // R3: done and armed never together
    assert_status_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_done && st_armed));

    // R6: a frozen buffer takes no writes
    assert_frozen_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> !wr_en);

    // R6: re-arm clears done
    assert_rearm_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && arm_req) |=> (!st_done && st_armed));

    // R2: undriven bus reads as zero
    assert_released_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dout_en |-> (bus_dout == '0));

endmodule

bind snap_capture_top snap_capture_chk #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_req    (arm_req),
    .smp_valid  (smp_valid),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .st_done    (st_done),
    .st_armed   (st_armed),
    .bus_dout_en(bus_dout_en),
    .bus_dout   (bus_dout)
);

// File: tb/tb_snap_capture_top.sv
module tb_snap_capture_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_i = '0, smp_q = '0, smp_sin = '0, smp_cos = '0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_din = '0;
    logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [15:0] bus_dout;
    logic        bus_dout_en;

    always #2 clk = ~clk;

    snap_capture_top dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q), .smp_sin(smp_sin), .smp_cos(smp_cos),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
    );

    typedef struct {
        logic [8:0]  addr;
        logic [15:0] data;
        logic        en;
        string       tag;
    } item_t;

    item_t       sb[$];
    event        mon_ev;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;

    // bench model of the capture buffer
    logic [15:0] exp_mem [256];
    bit          m_armed = 0;
    bit          m_done  = 0;
    int          m_cnt   = 0;

    function automatic logic [15:0] sval(int seed, int n, int lane);
        return 16'(lane * 16'h4000 + n * 97 + seed * 13 + lane * 5 + 1);
    endfunction

    function automatic logic [15:0] m_status();
        return {14'b0, m_armed, m_done};
    endfunction

    // monitor: pops expected items and compares against the port
    initial begin
        forever begin
            item_t it;
            @(mon_ev);
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard underflow: got en=%0b data=%h expected a queued item",
                         bus_dout_en, bus_dout);
            end else begin
                it = sb.pop_front();
                n_cmp++;
                if (bus_dout_en !== it.en || bus_dout !== it.data) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d got en=%0b data=%h expected en=%0b data=%h",
                             it.tag, it.addr, bus_dout_en, bus_dout, it.en, it.data);
                end
            end
        end
    end

    task automatic bus_probe(input logic [8:0] a, input logic cs, input logic rd,
                             input logic exp_en, input logic [15:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a; bus_cs_n = cs; bus_rd_n = rd;
        it.addr = a; it.data = exp; it.en = exp_en; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        ->mon_ev;
        #1;
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    endtask

    task automatic bus_read(input logic [8:0] a, input logic [15:0] exp, input string tag);
        bus_probe(a, 1'b0, 1'b0, 1'b1, exp, tag);
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [15:0] d, input int hold);
        @(negedge clk);
        bus_addr = a; bus_din = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        if (a == 9'd0 && d[0] && !(m_armed && m_cnt > 0)) begin
            m_armed = 1; m_done = 0; m_cnt = 0;
        end
        repeat (hold) @(negedge clk);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drive_samples(input int n, input int seed, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (gap > 0 && (k % gap) == gap - 1) begin
                smp_valid = 1'b0;
                @(negedge clk);
            end
            smp_valid = 1'b1;
            smp_i = sval(seed, k, 0); smp_q = sval(seed, k, 1);
            smp_sin = sval(seed, k, 2); smp_cos = sval(seed, k, 3);
            if (m_armed) begin
                exp_mem[4*m_cnt+0] = smp_i;
                exp_mem[4*m_cnt+1] = smp_q;
                exp_mem[4*m_cnt+2] = smp_sin;
                exp_mem[4*m_cnt+3] = smp_cos;
                m_cnt++;
                if (m_cnt == 64) begin m_armed = 0; m_done = 1; end
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < 256; k++) bus_read(9'(256 + k), exp_mem[k], tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected the run to end");
        summary();
    end

    initial begin
        for (int k = 0; k < 256; k++) exp_mem[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and released bus
        bus_probe(9'd1, 1'b1, 1'b1, 1'b0, 16'h0, "R1 idle bus");
        bus_read(9'd1, 16'h0000, "R1 status after reset");
        // R9: control and unmapped read as zero
        bus_read(9'd0, 16'h0000, "R9 ctrl addr");
        bus_read(9'd5, 16'h0000, "R9 unmapped 5");
        bus_read(9'd255, 16'h0000, "R9 unmapped 255");
        // R2: a single strobe does not drive
        bus_probe(9'd1, 1'b0, 1'b1, 1'b0, 16'h0, "R2 cs only");
        bus_probe(9'd1, 1'b1, 1'b0, 1'b0, 16'h0, "R2 rd only");

        // R8: bit 0 clear does not arm
        bus_write(9'd0, 16'hFFFE, 1);
        bus_read(9'd1, m_status(), "R8 arm bit clear");
        // R3: arm, with a held strobe
        bus_write(9'd0, 16'h0001, 4);
        bus_read(9'd1, 16'h0002, "R3 armed status");
        drive_samples(0, 0, 0);
        bus_read(9'd1, 16'h0002, "R3 still armed without valid");

        // R4: gapped fill, R8: arm during fill ignored
        drive_samples(20, 1, 3);
        bus_write(9'd0, 16'h0001, 3);
        bus_read(9'd1, 16'h0002, "R8 arm during fill");
        drive_samples(43, 21, 4);
        bus_read(9'd1, 16'h0002, "R4 armed at 63 samples");
        drive_samples(1, 64, 0);
        bus_read(9'd1, 16'h0001, "R4 done after 64");

        // R6: frozen after done
        drive_samples(5, 9, 0);
        bus_read(9'd1, m_status(), "R6 status stays done");
        // R7: writes to capture region ignored
        bus_write(9'd256, 16'hDEAD, 1);
        bus_write(9'd300, 16'hBEEF, 1);
        bus_write(9'd511, 16'h0F0F, 1);
        // R5: layout of the whole block
        read_all("R5 layout");
        bus_read(9'd256, exp_mem[0], "R7 word 256 kept");
        bus_read(9'd511, exp_mem[255], "R7 word 511 kept");

        // R6: re-arm clears done and overwrites
        bus_write(9'd0, 16'h0001, 1);
        bus_read(9'd1, 16'h0002, "R6 rearm clears done");
        drive_samples(64, 2, 0);
        bus_read(9'd1, 16'h0001, "R6 second capture done");
        read_all("R6 overwrite");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule